// File: doc/BRIEF.md
# Multi-class wormhole input port

This block is one input port of a five-port mesh router. Flits arrive from the upstream router one per cycle. Each flit carries a type, a service class and a payload. The flit is stored in a small FIFO that belongs to its class. There are four classes, each with a FIFO of its own, so a packet of one class never blocks a packet of another class inside the port.

When a head flit reaches the front of its class FIFO, the port works out the output direction. It does this from signed X/Y hop offsets held in the head payload, and it resolves X before Y. The head flit is offered downstream with the offset for the chosen hop moved one step toward zero. The chosen direction is then kept for that class alone until the tail flit leaves. This lets packets of different classes share the link flit by flit.

For each class the port shows a request, a one-hot output direction and the outgoing flit. The output side answers with a pop. Every accepted pop sends a one-cycle credit pulse upstream on that class's own credit wire.

Top module: `mcw_inport`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, every request and every credit output is low.
- R2: An incoming flit whose type field `in_flit[19:18]` is not idle (00) is written into the FIFO selected by `in_flit[17:16]`. The request of that class is high in the cycle after the write edge. An idle flit changes no class's request.
- R3: Each class FIFO holds up to 4 flits (depth parameter) and returns them in arrival order. A write to a full FIFO is a protocol error and is flagged.
- R4: For a head flit (type 01), the X offset is `payload[3:0]` and the Y offset is `payload[7:4]`, both signed. The direction is east if X>0 and west if X<0. When X=0 it is north if Y>0 and south if Y<0. When X=0 and Y=0 it is local. The direction is one-hot with bit 0 local, bit 1 north, bit 2 south, bit 3 east, bit 4 west.
- R5: Body (10) and tail (11) flits of a class are offered on the direction latched when that class's head was popped. The latched direction is released when the tail is popped, so the next head of that class is routed again.
- R6: The offered head flit carries the offset of the hop just taken moved one step toward zero: X if X was nonzero, otherwise Y. A local head is unchanged. Body and tail flits, and the payload bits above bit 7, pass unchanged.
- R7: A pop on a class with a pending request raises that class's credit for exactly the next cycle. A pop on an empty class produces no credit and no change.
- R8: Routing state is kept per class, so interleaved packets of different classes each keep their own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_flit | input | 20 | Incoming flit: type[19:18], class[17:16], payload[15:0] |
| pop | input | 4 | Per-class accept from the output side |
| req | output | 4 | Per-class head-of-line flit pending |
| req_port | output | 20 | Per-class one-hot direction, 5 bits per class |
| req_flit | output | 80 | Per-class outgoing flit, 20 bits per class |
| credit | output | 4 | Per-class one-cycle credit pulse upstream |

## Verification
A flit driven before a rising edge is written at that edge. Its request, direction and outgoing flit are valid right after that edge, so the bench checks them at the following falling edge. A pop is seen at one rising edge. The credit for it and the next head-of-line flit are valid right after that edge, and the bench samples both at the next falling edge. No check is made in the same half-cycle in which its stimulus changes.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
  localparam int NUM_CLS  = 4;
  localparam int NUM_PORT = 5;

  localparam logic [1:0] FT_IDLE = 2'b00;
  localparam logic [1:0] FT_HEAD = 2'b01;
  localparam logic [1:0] FT_BODY = 2'b10;
  localparam logic [1:0] FT_TAIL = 2'b11;

  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_SOUTH = 2;
  localparam int P_EAST  = 3;
  localparam int P_WEST  = 4;

  // X resolved first, then Y, local when both are zero
  function automatic logic [NUM_PORT-1:0] dor_pick(input logic [3:0] dx, input logic [3:0] dy);
    logic [NUM_PORT-1:0] r;
    r = '0;
    if (dx != 4'd0)      r[dx[3] ? P_WEST : P_EAST] = 1'b1;
    else if (dy != 4'd0) r[dy[3] ? P_SOUTH : P_NORTH] = 1'b1;
    else                 r[P_LOCAL] = 1'b1;
    return r;
  endfunction

  // one hop nearer to zero for a signed 4-bit offset
  function automatic logic [3:0] toward_zero(input logic [3:0] v);
    if (v == 4'd0) return v;
    return v[3] ? v + 4'd1 : v - 4'd1;
  endfunction
endpackage

// File: rtl/mcw_fifo.sv
module mcw_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= wdata;
        wr_ptr      <= wrap_inc(wr_ptr);
      end
      if (do_pop) rd_ptr <= wrap_inc(rd_ptr);
      if (do_push && !do_pop)      level <= level + CW'(1);
      else if (do_pop && !do_push) level <= level - CW'(1);
    end
  end

  // credits upstream must never let a full buffer be written
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // a lone accepted write makes the buffer non-empty next cycle
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/mcw_route.sv
module mcw_route
  import mcw_pkg::*;
#(
  parameter int PAY_W = 16
) (
  input  logic [PAY_W-1:0]    pay_in,
  output logic [NUM_PORT-1:0] dir,
  output logic [PAY_W-1:0]    pay_out
);
  logic [3:0] dx, dy;

  assign dx  = pay_in[3:0];
  assign dy  = pay_in[7:4];
  assign dir = dor_pick(dx, dy);

  always_comb begin
    pay_out = pay_in;
    if (dx != 4'd0)      pay_out[3:0] = toward_zero(dx);
    else if (dy != 4'd0) pay_out[7:4] = toward_zero(dy);
  end
endmodule

// File: rtl/mcw_lane.sv
module mcw_lane
  import mcw_pkg::*;
#(
  parameter int FLIT_W = 20,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [FLIT_W-1:0]   push_flit,
  input  logic                pop,
  output logic                req,
  output logic [NUM_PORT-1:0] req_port,
  output logic [FLIT_W-1:0]   req_flit,
  output logic                credit
);
  localparam int PAY_W = FLIT_W - 4;

  logic [FLIT_W-1:0]   hol;
  logic                empty, full;
  logic [1:0]          hol_type;
  logic                hol_head;
  logic [NUM_PORT-1:0] calc_port, held_port;
  logic [PAY_W-1:0]    next_pay;
  logic                route_live;
  logic                taken;

  mcw_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_flit),
    .pop(taken), .rdata(hol), .empty(empty), .full(full)
  );

  mcw_route #(.PAY_W(PAY_W)) u_route (
    .pay_in(hol[PAY_W-1:0]), .dir(calc_port), .pay_out(next_pay)
  );

  assign hol_type = hol[FLIT_W-1 -: 2];
  assign hol_head = (hol_type == FT_HEAD);
  assign req      = !empty;
  assign taken    = pop && req;
  assign req_port = hol_head ? calc_port : held_port;
  assign req_flit = hol_head ? {hol[FLIT_W-1 -: 4], next_pay} : hol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_port  <= '0;
      route_live <= 1'b0;
      credit     <= 1'b0;
    end else begin
      credit <= taken;
      if (taken && hol_head) begin
        held_port  <= calc_port;
        route_live <= 1'b1;
      end else if (taken && hol_type == FT_TAIL) begin
        route_live <= 1'b0;
      end
    end
  end

  // every offered flit names exactly one output
  assert_route_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hol_type != FT_IDLE) |-> ($countones(req_port) == 1));

  // body and tail only appear while a head route is latched
  assert_body_has_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hol_head) |-> route_live);

  // the FIFO never stores an idle flit
  assert_no_idle_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (hol_type != FT_IDLE));
endmodule

// File: rtl/mcw_inport.sv
module mcw_inport
  import mcw_pkg::*;
#(
  parameter int FLIT_W = 20,
  parameter int DEPTH  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [FLIT_W-1:0]              in_flit,
  input  logic [NUM_CLS-1:0]             pop,
  output logic [NUM_CLS-1:0]             req,
  output logic [NUM_CLS*NUM_PORT-1:0]    req_port,
  output logic [NUM_CLS*FLIT_W-1:0]      req_flit,
  output logic [NUM_CLS-1:0]             credit
);
  logic [1:0]         in_type;
  logic [1:0]         in_cls;
  logic [NUM_CLS-1:0] push_vec;

  assign in_type = in_flit[FLIT_W-1 -: 2];
  assign in_cls  = in_flit[FLIT_W-3 -: 2];

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_lane
    assign push_vec[c] = (in_type != FT_IDLE) && (in_cls == 2'(c));

    mcw_lane #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .push(push_vec[c]), .push_flit(in_flit),
      .pop(pop[c]),
      .req(req[c]),
      .req_port(req_port[c*NUM_PORT +: NUM_PORT]),
      .req_flit(req_flit[c*FLIT_W +: FLIT_W]),
      .credit(credit[c])
    );
  end

  // one arriving flit lands in at most one class buffer
  assert_single_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(push_vec) <= 1);

  // a credit is only returned after a pop on a class that had a flit
  assert_credit_after_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (credit != '0) |-> ($past(pop & req) == credit));
endmodule

// File: tb/mcw_inport_test.sv
module mcw_inport_test;
  localparam int CLK_T = 10;
  localparam int FW = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] in_flit;
  logic [3:0]  pop;
  logic [3:0]  req;
  logic [19:0] req_port;
  logic [79:0] req_flit;
  logic [3:0]  credit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  mcw_inport uut (
    .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .pop(pop),
    .req(req), .req_port(req_port), .req_flit(req_flit), .credit(credit)
  );

  always #(CLK_T/2) clk = ~clk;

  localparam logic [4:0] D_LOC = 5'b00001, D_N = 5'b00010, D_S = 5'b00100,
                         D_E = 5'b01000, D_W = 5'b10000;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input logic [1:0] t, input logic [1:0] c, input logic [15:0] p);
    return {t, c, p};
  endfunction

  // called at a falling edge, returns at the next falling edge
  task automatic send(input logic [19:0] f);
    in_flit = f;
    @(negedge clk);
    in_flit = '0;
  endtask

  task automatic take(input int c);
    pop[c] = 1'b1;
    @(negedge clk);
    pop = '0;
  endtask

  task automatic t_reset;
    chk(32'(req), 32'h0, "R1 req after reset");
    chk(32'(credit), 32'h0, "R1 credit after reset");
  endtask

  task automatic route_case(input int c, input logic [3:0] x, input logic [3:0] y,
                            input logic [4:0] ed, input logic [3:0] ex, input logic [3:0] ey);
    send(mk(2'b01, 2'(c), {8'hA5, y, x}));
    chk(32'(req[c]), 1, "R2 req after head write");
    send(mk(2'b11, 2'(c), 16'h1234));
    chk(32'(req_port[c*5 +: 5]), 32'(ed), "R4 head direction");
    chk(32'(req_flit[c*FW +: FW]), 32'(mk(2'b01, 2'(c), {8'hA5, ey, ex})), "R6 head offsets");
    take(c);
    chk(32'(credit[c]), 1, "R7 credit after pop");
    chk(32'(req_port[c*5 +: 5]), 32'(ed), "R5 tail keeps direction");
    chk(32'(req_flit[c*FW +: FW]), 32'(mk(2'b11, 2'(c), 16'h1234)), "R6 tail unchanged");
    take(c);
    chk(32'(credit[c]), 1, "R7 credit after tail pop");
    chk(32'(req[c]), 0, "R3 lane empty after packet");
  endtask

  task automatic t_routes;
    route_case(0, 4'h3, 4'hE, D_E, 4'h2, 4'hE);
    route_case(0, 4'hF, 4'h5, D_W, 4'h0, 4'h5);
    route_case(1, 4'h0, 4'h4, D_N, 4'h0, 4'h3);
    route_case(3, 4'h0, 4'h8, D_S, 4'h0, 4'h9);
    route_case(2, 4'h0, 4'h0, D_LOC, 4'h0, 4'h0);
  endtask

  task automatic t_order;
    send(mk(2'b00, 2'd2, 16'hFFFF));
    chk(32'(req), 0, "R2 idle flit ignored");
    send(mk(2'b01, 2'd2, 16'h7700));
    send(mk(2'b10, 2'd2, 16'h1111));
    send(mk(2'b10, 2'd2, 16'h2222));
    send(mk(2'b11, 2'd2, 16'h3333));
    chk(32'(req_flit[2*FW +: FW]), 32'(mk(2'b01, 2'd2, 16'h7700)), "R3 first out");
    take(2);
    chk(32'(req_flit[2*FW +: FW]), 32'(mk(2'b10, 2'd2, 16'h1111)), "R3 second out");
    take(2);
    chk(32'(req_flit[2*FW +: FW]), 32'(mk(2'b10, 2'd2, 16'h2222)), "R3 third out");
    chk(32'(req_port[2*5 +: 5]), 32'(D_LOC), "R5 body local");
    take(2);
    chk(32'(req_flit[2*FW +: FW]), 32'(mk(2'b11, 2'd2, 16'h3333)), "R3 fourth out");
    take(2);
    chk(32'(req[2]), 0, "R3 drained");
  endtask

  task automatic t_empty_pop;
    take(1);
    chk(32'(credit[1]), 0, "R7 no credit on empty pop");
    chk(32'(req[1]), 0, "R7 empty pop no effect");
  endtask

  task automatic t_interleave;
    send(mk(2'b01, 2'd1, 16'h0002));
    send(mk(2'b01, 2'd3, 16'h00D0));
    send(mk(2'b10, 2'd1, 16'hB001));
    send(mk(2'b10, 2'd3, 16'hB003));
    send(mk(2'b11, 2'd1, 16'hC001));
    send(mk(2'b11, 2'd3, 16'hC003));
    take(1);
    take(3);
    chk(32'(req_port[1*5 +: 5]), 32'(D_E), "R8 class1 body east");
    chk(32'(req_port[3*5 +: 5]), 32'(D_S), "R8 class3 body south");
    take(1);
    take(3);
    chk(32'(req_flit[1*FW +: FW]), 32'(mk(2'b11, 2'd1, 16'hC001)), "R8 class1 tail");
    chk(32'(req_port[1*5 +: 5]), 32'(D_E), "R8 class1 tail east");
    chk(32'(req_port[3*5 +: 5]), 32'(D_S), "R8 class3 tail south");
    take(1);
    take(3);
    chk(32'(req), 0, "R8 all drained");
  endtask

  initial begin
    rst_n = 1'b0;
    in_flit = '0;
    pop = '0;
    repeat (3) @(negedge clk);
    chk(32'(req | credit), 0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_routes;
    t_order;
    t_empty_pop;
    t_interleave;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule